// File: doc/BRIEF.md
# Block-Based Table Access Protection Unit

This unit sits between the table read and table write path of a processor and its program memory. Program memory is split into a small boot region followed by a parameterised number of equal blocks. Every table access presents a target address and the program counter of the instruction making the access. The unit decides whether a write may reach memory, and whether read data passes through or is replaced by zeros. Addresses above the last block, such as the configuration and identification space, are always open to table access.

Each region has three protection flags: a write guard, a read guard and a code guard. A flag value of 1 means open and 0 means protected. Software may only clear flags. Only an erase request from the programming side sets them back to 1. The code guard has no effect on table accesses. It only decides whether an access from the external programming port to that region is permitted.

Writes go through a small state machine with three states: `ACC_IDLE`, `ACC_GRANT` and `ACC_DENY`. From any state, a cycle with a write request moves the machine to `ACC_GRANT` if the write is allowed, or to `ACC_DENY` if it is not. A cycle without a write request returns it to `ACC_IDLE`. `ACC_GRANT` drives a one-cycle write strobe to memory. `ACC_DENY` drives a one-cycle blocked flag. Reads are decided combinationally in the same cycle.

Top module: `tap_guard`

## Requirements
- R1: Regions are decoded as follows. Addresses 0x000–0x1FF form the boot region, with erase and flag index NUM_BLOCKS (4 by default). Block k (index k) covers k·2^BLOCK_SHIFT up to (k+1)·2^BLOCK_SHIFT−1, except that block 0 starts at 0x200. Addresses at or above NUM_BLOCKS·2^BLOCK_SHIFT belong to no region.
- R2: A table write whose target lies in a region with write guard 0 is blocked, wherever the program counter is. One cycle after the request, wr_blocked is 1 for exactly one cycle and mem_wr_en stays 0.
- R3: A permitted table write produces mem_wr_en = 1 for exactly one cycle, one cycle after the request, with mem_wr_addr and mem_wr_data equal to the requested address and data. wr_blocked stays 0.
- R4: A table read of a region with read guard 0 passes only when the program counter is in that same region. Otherwise rd_data is all zeros and rd_denied is 1.
- R5: A table read of a region with read guard 1 passes mem_rd_data through from any program counter, with rd_denied 0.
- R6: Table reads and writes of addresses outside every region are always permitted.
- R7: A flag update (cfg_wr_en) sets each flag to old AND requested. A request to turn a 0 flag into 1 is ignored.
- R8: erase_all sets every flag to 1. erase_blk_en sets only the three flags of region erase_blk_idx to 1. An erase wins over a flag update in the same cycle.
- R9: Code guard flags do not affect table reads or writes. ext_ok is 1 for an ext_addr outside every region, and otherwise equals the code guard flag of its region.
- R10: With BLOCK_SHIFT = 13 (8 KB blocks), the same rules hold on the shifted boundaries.
- R11: After reset, the flags hold the parameters WRT_INIT, RDP_INIT and CP_INIT. By default these are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_addr | input | ADDR_W | Table access target address |
| pc_addr | input | ADDR_W | Program counter of the accessing instruction |
| tbl_rd | input | 1 | Table read in progress |
| tbl_wr | input | 1 | Table write request |
| tbl_wr_data | input | DATA_W | Data to write |
| mem_rd_data | input | DATA_W | Raw data read from memory |
| rd_data | output | DATA_W | Read data after masking |
| rd_denied | output | 1 | Current read is masked |
| mem_wr_en | output | 1 | Write strobe toward memory |
| mem_wr_addr | output | ADDR_W | Registered write address |
| mem_wr_data | output | DATA_W | Registered write data |
| wr_blocked | output | 1 | One-cycle pulse for a refused write |
| cfg_wr_en | input | 1 | Software flag update |
| cfg_wrt_keep | input | NUM_BLOCKS+1 | Requested write guard flags (ANDed in) |
| cfg_rdp_keep | input | NUM_BLOCKS+1 | Requested read guard flags (ANDed in) |
| cfg_cp_keep | input | NUM_BLOCKS+1 | Requested code guard flags (ANDed in) |
| erase_all | input | 1 | Set every flag to 1 |
| erase_blk_en | input | 1 | Set the flags of one region to 1 |
| erase_blk_idx | input | IDX_W | Region index for erase_blk_en |
| ext_addr | input | ADDR_W | Address from the external programming port |
| ext_ok | output | 1 | External access permitted |

## Verification
Two situations are hard to reach from the ports. The first is a read of a guarded region that passes only because the program counter sits in the same region. The stimulus reaches it by crossing every region's first and last address as a target with the same set as a program counter, under all 32 read guard patterns. The second is an erase arriving in the same cycle as a software clear of the same region. The bench drives both strobes in one cycle and then probes writes to every region. Run-time flags come only from an erase followed by a clearing update, so every flag combination is reached through the legal one-way path.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_GRANT = 2'd1,
        ACC_DENY  = 2'd2
    } acc_state_e;

    localparam int DEF_ADDR_W      = 21;
    localparam int DEF_DATA_W      = 8;
    localparam int DEF_BLOCK_SHIFT = 14;
    localparam int DEF_NUM_BLOCKS  = 4;
    localparam int DEF_BOOT_SIZE   = 512;

endpackage

// File: rtl/tap_region_decode.sv
module tap_region_decode #(
    parameter int ADDR_W      = tap_pkg::DEF_ADDR_W,
    parameter int BLOCK_SHIFT = tap_pkg::DEF_BLOCK_SHIFT,
    parameter int NUM_BLOCKS  = tap_pkg::DEF_NUM_BLOCKS,
    parameter int BOOT_SIZE   = tap_pkg::DEF_BOOT_SIZE,
    parameter int IDX_W       = $clog2(NUM_BLOCKS + 1)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output logic              guarded
);
    localparam logic [ADDR_W:0] END_A  = (ADDR_W+1)'(NUM_BLOCKS) << BLOCK_SHIFT;
    localparam logic [ADDR_W:0] BOOT_A = (ADDR_W+1)'(BOOT_SIZE);

    logic [ADDR_W:0]   wide;
    logic [ADDR_W-1:0] shifted;

    assign wide    = {1'b0, addr};
    assign shifted = addr >> BLOCK_SHIFT;

    always_comb begin
        guarded = (wide < END_A);
        if (wide < BOOT_A) begin
            idx = IDX_W'(NUM_BLOCKS);
        end else begin
            idx = shifted[IDX_W-1:0];
        end
    end
endmodule

// File: rtl/tap_prot_regs.sv
module tap_prot_regs #(
    parameter int NREG = tap_pkg::DEF_NUM_BLOCKS + 1,
    parameter int IDX_W = $clog2(NREG),
    parameter logic [NREG-1:0] WRT_INIT = '1,
    parameter logic [NREG-1:0] RDP_INIT = '1,
    parameter logic [NREG-1:0] CP_INIT  = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr_en,
    input  logic [NREG-1:0] cfg_wrt_keep,
    input  logic [NREG-1:0] cfg_rdp_keep,
    input  logic [NREG-1:0] cfg_cp_keep,
    input  logic            erase_all,
    input  logic            erase_blk_en,
    input  logic [IDX_W-1:0] erase_blk_idx,
    output logic [NREG-1:0] wrt_q,
    output logic [NREG-1:0] rdp_q,
    output logic [NREG-1:0] cp_q
);
    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_flag
            logic restore;
            assign restore = erase_all ||
                             (erase_blk_en && (erase_blk_idx == IDX_W'(g)));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wrt_q[g] <= WRT_INIT[g];
                    rdp_q[g] <= RDP_INIT[g];
                    cp_q[g]  <= CP_INIT[g];
                end else if (restore) begin
                    wrt_q[g] <= 1'b1;
                    rdp_q[g] <= 1'b1;
                    cp_q[g]  <= 1'b1;
                end else if (cfg_wr_en) begin
                    wrt_q[g] <= wrt_q[g] & cfg_wrt_keep[g];
                    rdp_q[g] <= rdp_q[g] & cfg_rdp_keep[g];
                    cp_q[g]  <= cp_q[g]  & cfg_cp_keep[g];
                end
            end
        end
    endgenerate

    // R7: without an erase, no flag ever rises
    p_only_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!erase_all && !erase_blk_en) |=>
            (((wrt_q & ~$past(wrt_q)) == '0) &&
             ((rdp_q & ~$past(rdp_q)) == '0) &&
             ((cp_q  & ~$past(cp_q))  == '0)));

    // R8: full erase opens everything
    p_erase_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_all |=> ((&wrt_q) && (&rdp_q) && (&cp_q)));

    // R8: block erase opens the selected region
    p_blk_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_blk_en && (erase_blk_idx < IDX_W'(NREG))) |=>
            (wrt_q[$past(erase_blk_idx)] && rdp_q[$past(erase_blk_idx)]
             && cp_q[$past(erase_blk_idx)]));
endmodule

// File: rtl/tap_access_fsm.sv
module tap_access_fsm
    import tap_pkg::*;
#(
    parameter int ADDR_W = tap_pkg::DEF_ADDR_W,
    parameter int DATA_W = tap_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_wr,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [DATA_W-1:0] tbl_wr_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              wr_blocked
);
    acc_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (tbl_wr) begin
            addr_q <= tbl_addr;
            data_q <= tbl_wr_data;
        end
    end

    always_comb begin
        state_d = ACC_IDLE;
        unique case (state_q)
            ACC_IDLE, ACC_GRANT, ACC_DENY: begin
                if (tbl_wr) begin
                    state_d = wr_ok ? ACC_GRANT : ACC_DENY;
                end else begin
                    state_d = ACC_IDLE;
                end
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    always_comb begin
        mem_wr_en   = 1'b0;
        wr_blocked  = 1'b0;
        mem_wr_addr = addr_q;
        mem_wr_data = data_q;
        unique case (state_q)
            ACC_IDLE:  ;
            ACC_GRANT: mem_wr_en  = 1'b1;
            ACC_DENY:  wr_blocked = 1'b1;
            default:   ;
        endcase
    end

    // R2: a refused write never strobes memory
    p_no_dual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && wr_blocked));

    // R2: a blocked pulse always answers a request one cycle earlier
    p_deny_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_blocked |-> $past(tbl_wr));

    // R3: a strobe always answers a request one cycle earlier
    p_grant_after_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(tbl_wr));
endmodule

// File: rtl/tap_guard.sv
module tap_guard #(
    parameter int ADDR_W      = tap_pkg::DEF_ADDR_W,
    parameter int DATA_W      = tap_pkg::DEF_DATA_W,
    parameter int BLOCK_SHIFT = tap_pkg::DEF_BLOCK_SHIFT,
    parameter int NUM_BLOCKS  = tap_pkg::DEF_NUM_BLOCKS,
    parameter int BOOT_SIZE   = tap_pkg::DEF_BOOT_SIZE,
    parameter int NREG        = NUM_BLOCKS + 1,
    parameter int IDX_W       = $clog2(NUM_BLOCKS + 1),
    parameter logic [NUM_BLOCKS:0] WRT_INIT = '1,
    parameter logic [NUM_BLOCKS:0] RDP_INIT = '1,
    parameter logic [NUM_BLOCKS:0] CP_INIT  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [ADDR_W-1:0] pc_addr,
    input  logic              tbl_rd,
    input  logic              tbl_wr,
    input  logic [DATA_W-1:0] tbl_wr_data,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_denied,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              wr_blocked,
    input  logic              cfg_wr_en,
    input  logic [NREG-1:0]   cfg_wrt_keep,
    input  logic [NREG-1:0]   cfg_rdp_keep,
    input  logic [NREG-1:0]   cfg_cp_keep,
    input  logic              erase_all,
    input  logic              erase_blk_en,
    input  logic [IDX_W-1:0]  erase_blk_idx,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              ext_ok
);
    localparam int N_DEC  = 3;
    localparam int D_TGT  = 0;
    localparam int D_PC   = 1;
    localparam int D_EXT  = 2;

    logic [ADDR_W-1:0] dec_addr  [N_DEC];
    logic [IDX_W-1:0]  dec_idx   [N_DEC];
    logic              dec_guard [N_DEC];

    assign dec_addr[D_TGT] = tbl_addr;
    assign dec_addr[D_PC]  = pc_addr;
    assign dec_addr[D_EXT] = ext_addr;

    genvar d;
    generate
        for (d = 0; d < N_DEC; d++) begin : g_dec
            tap_region_decode #(
                .ADDR_W      (ADDR_W),
                .BLOCK_SHIFT (BLOCK_SHIFT),
                .NUM_BLOCKS  (NUM_BLOCKS),
                .BOOT_SIZE   (BOOT_SIZE),
                .IDX_W       (IDX_W)
            ) u_dec (
                .addr    (dec_addr[d]),
                .idx     (dec_idx[d]),
                .guarded (dec_guard[d])
            );
        end
    endgenerate

    logic [NREG-1:0] wrt_q, rdp_q, cp_q;

    tap_prot_regs #(
        .NREG     (NREG),
        .IDX_W    (IDX_W),
        .WRT_INIT (WRT_INIT),
        .RDP_INIT (RDP_INIT),
        .CP_INIT  (CP_INIT)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wrt_keep  (cfg_wrt_keep),
        .cfg_rdp_keep  (cfg_rdp_keep),
        .cfg_cp_keep   (cfg_cp_keep),
        .erase_all     (erase_all),
        .erase_blk_en  (erase_blk_en),
        .erase_blk_idx (erase_blk_idx),
        .wrt_q         (wrt_q),
        .rdp_q         (rdp_q),
        .cp_q          (cp_q)
    );

    logic wr_ok, rd_ok, same_region;

    always_comb begin
        same_region = dec_guard[D_PC] && (dec_idx[D_PC] == dec_idx[D_TGT]);
        wr_ok  = !dec_guard[D_TGT] || wrt_q[dec_idx[D_TGT]];
        rd_ok  = !dec_guard[D_TGT] || rdp_q[dec_idx[D_TGT]] || same_region;
        ext_ok = !dec_guard[D_EXT] || cp_q[dec_idx[D_EXT]];
        rd_denied = tbl_rd && !rd_ok;
        rd_data   = rd_denied ? '0 : mem_rd_data;
    end

    tap_access_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tbl_wr      (tbl_wr),
        .wr_ok       (wr_ok),
        .tbl_addr    (tbl_addr),
        .tbl_wr_data (tbl_wr_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data),
        .wr_blocked  (wr_blocked)
    );

    // R4: a denied read presents zeros
    p_mask_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_denied |-> (rd_data == '0));

    // R4: an instruction inside the target region is never refused
    p_own_region_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd && dec_guard[D_TGT] && dec_guard[D_PC] &&
         (dec_idx[D_PC] == dec_idx[D_TGT])) |-> !rd_denied);

    // R6: space beyond the blocks is always readable
    p_open_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_rd && !dec_guard[D_TGT]) |-> !rd_denied);
endmodule

// File: tb/tb_tap_guard.sv
module tb_tap_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 21;
    localparam int DW = 8;
    localparam int NB = 4;
    localparam int NR = NB + 1;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [AW-1:0] tbl_addr = '0, pc_addr = '0, ext_addr = '0;
    logic tbl_rd = 1'b0, tbl_wr = 1'b0;
    logic [DW-1:0] tbl_wr_data = '0;
    logic [DW-1:0] mem_rd_data;
    logic cfg_wr_en = 1'b0, erase_all = 1'b0, erase_blk_en = 1'b0;
    logic [NR-1:0] cfg_wrt_keep = '1, cfg_rdp_keep = '1, cfg_cp_keep = '1;
    logic [IW-1:0] erase_blk_idx = '0;

    assign mem_rd_data = 8'h80 | tbl_addr[7:0];

    logic [DW-1:0] rd_data, rd_data8;
    logic rd_denied, rd_denied8, mem_wr_en, mem_wr_en8, wr_blocked, wr_blocked8;
    logic [AW-1:0] mem_wr_addr, mem_wr_addr8;
    logic [DW-1:0] mem_wr_data, mem_wr_data8;
    logic ext_ok, ext_ok8;

    tap_guard dut (
        .clk(clk), .rst_n(rst_n), .tbl_addr(tbl_addr), .pc_addr(pc_addr),
        .tbl_rd(tbl_rd), .tbl_wr(tbl_wr), .tbl_wr_data(tbl_wr_data),
        .mem_rd_data(mem_rd_data), .rd_data(rd_data), .rd_denied(rd_denied),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .wr_blocked(wr_blocked), .cfg_wr_en(cfg_wr_en), .cfg_wrt_keep(cfg_wrt_keep),
        .cfg_rdp_keep(cfg_rdp_keep), .cfg_cp_keep(cfg_cp_keep), .erase_all(erase_all),
        .erase_blk_en(erase_blk_en), .erase_blk_idx(erase_blk_idx),
        .ext_addr(ext_addr), .ext_ok(ext_ok)
    );

    tap_guard #(.BLOCK_SHIFT(13), .WRT_INIT(5'b11110)) dut8 (
        .clk(clk), .rst_n(rst_n), .tbl_addr(tbl_addr), .pc_addr(pc_addr),
        .tbl_rd(tbl_rd), .tbl_wr(tbl_wr), .tbl_wr_data(tbl_wr_data),
        .mem_rd_data(mem_rd_data), .rd_data(rd_data8), .rd_denied(rd_denied8),
        .mem_wr_en(mem_wr_en8), .mem_wr_addr(mem_wr_addr8), .mem_wr_data(mem_wr_data8),
        .wr_blocked(wr_blocked8), .cfg_wr_en(cfg_wr_en), .cfg_wrt_keep(cfg_wrt_keep),
        .cfg_rdp_keep(cfg_rdp_keep), .cfg_cp_keep(cfg_cp_keep), .erase_all(erase_all),
        .erase_blk_en(erase_blk_en), .erase_blk_idx(erase_blk_idx),
        .ext_addr(ext_addr), .ext_ok(ext_ok8)
    );

    int n_chk = 0, n_fail = 0;
    logic [NR-1:0] wrt_m = '1, rdp_m = '1, cp_m = '1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_at(input int i, input int sh);
        int k;
        if (i == 0) return '0;
        if (i == 1) return AW'(32'h1FF);
        if (i == 10) return AW'(NB << sh);
        if (i == 11) return AW'(32'h1FFFF0);
        k = (i - 2) / 2;
        if ((i % 2) == 0) return (k == 0) ? AW'(32'h200) : AW'(k << sh);
        return AW'(((k + 1) << sh) - 1);
    endfunction

    function automatic int reg_of(input logic [AW-1:0] a, input int sh);
        if (int'(a) < 32'h200) return NB;
        if (int'(a) < (NB << sh)) return int'(a) >> sh;
        return -1;
    endfunction

    task automatic cfg(input logic [NR-1:0] w, input logic [NR-1:0] r,
                       input logic [NR-1:0] c);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wrt_keep = w; cfg_rdp_keep = r; cfg_cp_keep = c;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        wrt_m &= w; rdp_m &= r; cp_m &= c;
    endtask

    task automatic wipe();
        @(negedge clk);
        erase_all = 1'b1;
        @(negedge clk);
        erase_all = 1'b0;
        wrt_m = '1; rdp_m = '1; cp_m = '1;
    endtask

    task automatic wipe_one(input int k);
        @(negedge clk);
        erase_blk_en = 1'b1; erase_blk_idx = IW'(k);
        @(negedge clk);
        erase_blk_en = 1'b0;
        wrt_m[k] = 1'b1; rdp_m[k] = 1'b1; cp_m[k] = 1'b1;
    endtask

    // Issues one write and checks the main instance against the model.
    task automatic probe_wr(input logic [AW-1:0] a, input logic [AW-1:0] pc,
                            input string tag_hint);
        int r;
        bit ok;
        string tag;
        r = reg_of(a, 14);
        ok = (r < 0) || wrt_m[r];
        tag = (tag_hint != "") ? tag_hint : ((r < 0) ? "R6" : (ok ? "R3" : "R2"));
        @(negedge clk);
        tbl_addr = a; pc_addr = pc; tbl_wr = 1'b1; tbl_wr_data = a[7:0] ^ 8'h3C;
        @(negedge clk);
        tbl_wr = 1'b0;
        chk(mem_wr_en == ok, tag, 32'(mem_wr_en), 32'(ok));
        chk(wr_blocked == !ok, tag, 32'(wr_blocked), 32'(!ok));
        if (ok) begin
            chk(mem_wr_addr == a, tag, 32'(mem_wr_addr), 32'(a));
            chk(mem_wr_data == (a[7:0] ^ 8'h3C), tag, 32'(mem_wr_data),
                32'(a[7:0] ^ 8'h3C));
        end
        @(negedge clk);
        chk(!mem_wr_en && !wr_blocked, tag, {30'd0, mem_wr_en, wr_blocked}, 32'd0);
    endtask

    task automatic sweep_reads(input int sh, input bit use8);
        for (int ti = 0; ti < 12; ti++) begin
            for (int pi = 0; pi < 12; pi++) begin
                int r;
                bit ok;
                string tag;
                logic [DW-1:0] exp_d;
                logic [DW-1:0] got_d;
                logic got_n;
                tbl_addr = addr_at(ti, sh);
                pc_addr  = addr_at(pi, sh);
                tbl_rd   = 1'b1;
                #1;
                r = reg_of(tbl_addr, sh);
                ok = (r < 0) || rdp_m[r] || (reg_of(pc_addr, sh) == r);
                tag = use8 ? "R10" : ((r < 0) ? "R6" : (rdp_m[r] ? "R5" : "R4"));
                exp_d = ok ? mem_rd_data : '0;
                got_d = use8 ? rd_data8 : rd_data;
                got_n = use8 ? rd_denied8 : rd_denied;
                chk(got_d == exp_d && got_n == !ok, tag,
                    {23'd0, got_n, got_d}, {23'd0, !ok, exp_d});
            end
        end
        tbl_rd = 1'b0;
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!mem_wr_en && !wr_blocked, "R11", {30'd0, mem_wr_en, wr_blocked}, 0);
        tbl_addr = AW'(32'h200); tbl_wr = 1'b1;
        @(negedge clk);
        tbl_wr = 1'b0;
        chk(mem_wr_en == 1'b1, "R11", 32'(mem_wr_en), 1);
        chk(wr_blocked8 == 1'b1 && mem_wr_en8 == 1'b0, "R11",
            {30'd0, wr_blocked8, mem_wr_en8}, 32'd2);
        @(negedge clk);
        tbl_addr = AW'(32'h2000); tbl_wr = 1'b1;
        @(negedge clk);
        tbl_wr = 1'b0;
        chk(mem_wr_en8 == 1'b1, "R10", 32'(mem_wr_en8), 1);

        // R1 R2 R3 R4 R5 R6 R7 R10: every write and read guard pattern
        for (int p = 0; p < 32; p++) begin
            logic [NR-1:0] wp, rp;
            wp = NR'(p);
            rp = {wp[2:0], wp[4:3]};
            wipe();
            cfg(wp, rp, '1);
            // R7: requests to raise cleared flags are ignored
            cfg('1, '1, '1);
            sweep_reads(14, 1'b0);
            sweep_reads(13, 1'b1);
            for (int ti = 0; ti < 12; ti++)
                probe_wr(addr_at(ti, 14), addr_at(11 - ti, 14), "");
        end

        // R8: block erase restores only its own region
        wipe();
        cfg('0, '1, '1);
        for (int k = 0; k < NR; k++) begin
            wipe_one(k);
            for (int ti = 0; ti < 10; ti += 2)
                probe_wr(addr_at(ti, 14), '0, "R8");
        end
        // R8: erase wins over a same-cycle clear
        wipe();
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wrt_keep = '0; cfg_rdp_keep = '1; cfg_cp_keep = '1;
        erase_blk_en = 1'b1; erase_blk_idx = IW'(2);
        @(negedge clk);
        cfg_wr_en = 1'b0; erase_blk_en = 1'b0;
        wrt_m = 5'b00100;
        for (int ti = 0; ti < 12; ti++)
            probe_wr(addr_at(ti, 14), '0, "R8");

        // R9: code guard gates only the external port
        for (int p = 0; p < 32; p++) begin
            wipe();
            cfg('1, '1, NR'(p));
            for (int ai = 0; ai < 12; ai++) begin
                int r;
                bit ok;
                ext_addr = addr_at(ai, 14);
                #1;
                r = reg_of(ext_addr, 14);
                ok = (r < 0) || cp_m[r];
                chk(ext_ok == ok, "R9", 32'(ext_ok), 32'(ok));
            end
            if (p == 0) begin
                sweep_reads(14, 1'b0);
                for (int ti = 0; ti < 12; ti++)
                    probe_wr(addr_at(ti, 14), addr_at(11 - ti, 14), "R9");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule